// File: doc/BRIEF.md
# Conversion Start and Settling Sequencer

This block decides when a sampling front end stops tracking and holds its input, and when the converter that follows runs. A conversion can be requested in two ways. The first is a rising edge on an asynchronous convert-start pin. The second is a one-cycle software start pulse from the control logic. In both cases hold is held back until a settling timer has run out. The timer stands in for the delay that an external filter or signal-conditioning stage needs once the multiplexer switches. A channel change reloads it, and so does a software start. The timer length is a programmable count of master clock cycles.

A request that arrives while the timer is still running is kept and served as soon as the timer reaches zero. Once hold is entered, the conversion runs for a fixed number of master clock cycles. Hold then returns to track, busy falls, and a one-cycle done pulse marks a valid result. A power-down level clears any waiting request and cancels a conversion in progress without reporting a result.

Top module: `conv_start_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `hold`, `busy` and `done` are all low.
- R2: The pin `cnv_pin` passes through a two-flop synchroniser and is edge-detected. The first clock edge that samples it high is edge 0. With the settling timer expired, `busy` and `hold` rise on clock edge 3.
- R3: A pulse on `chan_chg` or `sw_start` loads `settle_len` into the settling timer. The timer counts down by one per clock. No conversion starts while it is non-zero.
- R4: A pin edge seen while the timer runs is kept. Taking edge 0 as the edge that reloads the timer (or, if later, the edge at which the pin edge is detected), `busy` rises one clock after the timer reaches zero. For a pin edge together with a channel change this is edge max(2, settle_len)+1.
- R5: A `sw_start` pulse captured on edge 0 also requests a conversion. `busy` rises on edge `settle_len`+1.
- R6: `busy` and `hold` are equal and stay high for exactly CONV_CYCLES cycles (default 14). They then fall together, and `done` is high for exactly the first cycle after they fall.
- R7: Pin edges and `sw_start` pulses that arrive while `busy` is high start no conversion, either then or later.
- R8: The pin is edge-triggered. Holding `cnv_pin` high starts exactly one conversion.
- R9: While `pwr_down` is high, a waiting request is discarded and a running conversion is cancelled: `busy` and `hold` are low from the next edge. No `done` pulse is ever issued for a discarded or cancelled request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_pin | input | 1 | Asynchronous convert-start pin, acts on its rising edge |
| chan_chg | input | 1 | One-cycle pulse: channel selection changed |
| sw_start | input | 1 | One-cycle pulse: software conversion request |
| settle_len | input | SETTLE_W | Settling time in master clock cycles |
| pwr_down | input | 1 | Power-down level |
| hold | output | 1 | High while the track/hold is in hold |
| busy | output | 1 | High while a conversion runs |
| done | output | 1 | One-cycle strobe marking a valid result |

## Verification
The hardest case to reach is a pin edge that lands while the settling timer is still running. The block must remember that edge and serve it later, with no request visible at the ports in between. The bench reaches it by pulsing a channel change in the same cycle as the pin rise. It sweeps the settling length across values below, equal to and above the synchroniser latency, so the deferred start is measured on both sides of the crossover. Power-down is applied in two states: once while a request waits behind the timer, and once partway through a conversion. The bench then watches long enough to confirm that no late start and no done pulse appear.

// File: rtl/conv_start_seq.sv
module conv_start_seq #(
  parameter int CONV_CYCLES = 14,
  parameter int SETTLE_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnv_pin,
  input  logic                chan_chg,
  input  logic                sw_start,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                pwr_down,
  output logic                hold,
  output logic                busy,
  output logic                done
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [2:0]          sync_q;
  logic [SETTLE_W-1:0] settle_cnt;
  logic [CW-1:0]       conv_cnt;
  logic                pend;
  logic                pin_rise, req, go, settled;

  assign pin_rise = sync_q[1] & ~sync_q[2];
  assign req      = pin_rise | sw_start;
  assign settled  = (settle_cnt == '0);
  assign go       = pend & settled & ~busy & ~pwr_down;
  assign hold     = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], cnv_pin};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down)          settle_cnt <= '0;
    else if (chan_chg || sw_start)   settle_cnt <= settle_len;
    else if (!settled)               settle_cnt <= settle_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down) begin
      pend     <= 1'b0;
      busy     <= 1'b0;
      conv_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go)                pend <= 1'b0;
      else if (req && !busy) pend <= 1'b1;
      if (go) begin
        busy     <= 1'b1;
        conv_cnt <= '0;
      end else if (busy) begin
        if (conv_cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          conv_cnt <= conv_cnt + 1'b1;
        end
      end
    end
  end

  assert_idle_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !busy && !done);

  assert_start_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(settle_cnt == '0));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_chg && !pwr_down) |=> settle_cnt == $past(settle_len));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy) && $past(conv_cnt == LAST));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> conv_cnt <= LAST);

  assert_no_start_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> !pend);

  assert_powerdown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !busy && !done && !pend);
endmodule

// File: tb/conv_start_seq_test.sv
module conv_start_seq_test;
  localparam int N = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnv_pin = 1'b0, chan_chg = 1'b0, sw_start = 1'b0, pwr_down = 1'b0;
  logic [7:0] settle_len = '0;
  logic       hold, busy, done;

  int total = 0, bad = 0, cycles = 0;

  conv_start_seq #(.CONV_CYCLES(N), .SETTLE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cnv_pin(cnv_pin), .chan_chg(chan_chg),
    .sw_start(sw_start), .settle_len(settle_len), .pwr_down(pwr_down),
    .hold(hold), .busy(busy), .done(done));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet(input int ncyc, input string req);
    int seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (busy || hold || done) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic measure_conv(input string req);
    int len = 1, dn = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      chk(hold == busy, {req, " hold==busy"}, hold, busy);
      if (busy) len++;
      else begin dn = done; break; end
    end
    chk(len == N, {req, " R6 length"}, len, N);
    chk(dn == 1, {req, " R6 done after fall"}, dn, 1);
    @(negedge clk);
    chk(done == 0, {req, " R6 done one cycle"}, done, 0);
  endtask

  task automatic fire(input bit p, input bit s, input bit c, input int L,
                      input int exp_n, input string req);
    int n = 0;
    @(negedge clk);
    settle_len = 8'(L);
    if (p) cnv_pin = 1'b1;
    sw_start = s;
    chan_chg = c;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      sw_start = 1'b0;
      chan_chg = 1'b0;
      if (n == 3) cnv_pin = 1'b0;
      if (busy) break;
    end
    cnv_pin = 1'b0;
    chk(n == exp_n, req, n, exp_n);
    measure_conv(req);
  endtask

  initial begin
    int rises;
    bit prev;
    repeat (3) @(negedge clk);
    chk(!hold && !busy && !done, "R1 in reset", {hold, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hold && !busy && !done, "R1 after reset", {hold, busy, done}, 0);

    fire(1, 0, 0, 0, 4, "R2 pin start latency");
    quiet(5, "R2 no extra start");

    for (int L = 0; L <= 12; L++) begin
      fire(0, 1, 0, L, L + 2, "R5 sw start latency");
      quiet(3, "R5 idle after");
    end

    for (int L = 0; L <= 12; L++) begin
      fire(1, 0, 1, L, ((L > 2) ? L : 2) + 2, "R4 deferred pin edge");
      quiet(3, "R3 R4 idle after");
    end

    // R3: channel change alone starts nothing
    @(negedge clk); settle_len = 8'd5; chan_chg = 1'b1;
    @(negedge clk); chan_chg = 1'b0;
    quiet(12, "R3 channel change alone");

    // R7: requests during conversion are ignored
    fire(0, 1, 0, 0, 2, "R7 setup start");
    @(negedge clk); settle_len = 8'd0; sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    cnv_pin = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 3) cnv_pin = 1'b0;
      if (!busy) break;
    end
    chk(busy == 0, "R7 first conversion ends", busy, 0);
    @(negedge clk);
    quiet(25, "R7 no late start");

    // R8: pin held high gives one conversion
    rises = 0; prev = 0;
    @(negedge clk); cnv_pin = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (busy && !prev) rises++;
      prev = busy;
    end
    chk(rises == 1, "R8 level held high", rises, 1);
    cnv_pin = 1'b0;
    quiet(5, "R8 release");

    // R9: waiting request dropped by power-down
    @(negedge clk); settle_len = 8'd10; chan_chg = 1'b1; cnv_pin = 1'b1;
    @(negedge clk); chan_chg = 1'b0;
    repeat (3) @(negedge clk);
    cnv_pin = 1'b0; pwr_down = 1'b1;
    repeat (3) @(negedge clk);
    pwr_down = 1'b0;
    quiet(30, "R9 waiting request dropped");

    // R9: running conversion cancelled, no done
    @(negedge clk); settle_len = 8'd0; sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1, "R9 conversion running", busy, 1);
    pwr_down = 1'b1;
    @(negedge clk);
    chk(!busy && !hold, "R9 cancel next edge", busy, 0);
    quiet(5, "R9 quiet while down");
    pwr_down = 1'b0;
    quiet(25, "R9 no done for cancelled");

    // R9: start pulse during power-down ignored
    pwr_down = 1'b1;
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    pwr_down = 1'b0;
    quiet(20, "R9 start during power-down");

    fire(1, 0, 0, 0, 4, "R2 recovery after power-down");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule